// File: doc/BRIEF.md
# Two-Level Not-Most-Recent Victim Selector

This block holds the replacement state for each set of a 16-way set-associative cache and names the way to evict on a miss. The ways of a set form two groups of eight. Way `w` belongs to group `w[3]` and sits at position `w[2:0]` inside that group. The block does not keep a full recency order. For each set it stores three things: the group touched last, and for each group, the position touched last inside it.

The cache controller presents one access per cycle. An access carries a set index, a hit flag and the hit way, together with the valid bits of the addressed set. The selector drives the victim way combinationally from the current set index, valid bits and random source. On the clock edge of an access it records the accessed way as most recently used. On a hit that way is the hit way. On a miss it is the victim being filled. Tag storage, data storage and the tag comparison are outside this block.

Top module: `hnmru_repl`

## Requirements
- R1: After reset every set has group 0 as its most recent group and position 0 as the most recent position in both groups. The random source holds 16'hACE1, so with all ways valid the first victim of any set is way 10.
- R2: If any bit of `set_valid` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0.
- R3: If all 16 ways are valid, the group of `victim_way` (bit 3) differs from the set's most recent group.
- R4: If all ways are valid, the position of `victim_way` (bits 2:0) differs from the most recent position stored for the victim's group.
- R5: If all ways are valid, the victim position is `(M + 1 + (L[2:0] mod 7)) mod 8`. Here `M` is the stored most recent position of the victim group and `L` is the current random value.
- R6: The random value is a 16-bit shift register that shifts left on every clock after reset. Its new bit 0 is `L[15]^L[13]^L[12]^L[10]`.
- R7: An access with `acc_hit` high makes the hit way's group the most recent group of that set, and the hit way's position the most recent position of its group.
- R8: An access with `acc_hit` low applies the same update, using the `victim_way` presented in that cycle.
- R9: Without `acc_valid` no set changes state, and an access changes only the addressed set.
- R10: `victim_way` follows `acc_set` and `set_valid` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access occurs this cycle |
| acc_set | input | 6 | Set index of the access or lookup |
| acc_hit | input | 1 | Access hit (1) or miss with fill (0) |
| acc_hit_way | input | 4 | Way that hit; used only when `acc_hit` is 1 |
| set_valid | input | 16 | Valid bit of each way of the addressed set |
| victim_way | output | 4 | Way chosen for eviction |

## Verification
The bench runs sets with some ways invalid, where a design that checked the policy before the invalid ways would evict live data. It also runs hit and miss sequences on the same set in consecutive cycles. There, a design that updated from the wrong way, or only on hits, would pick a victim from the group that was just touched. Accesses to neighbouring sets, mixed with idle cycles, expose a write that lands on the wrong set index or that happens without an access. A cycle-by-cycle comparison of the victim against an independent random-source model catches an off-by-one in the rotation, which would sometimes evict the most recent way itself.

// File: rtl/hnmru_pkg.sv
package hnmru_pkg;

  localparam int          RND_W    = 16;
  localparam logic [15:0] RND_SEED = 16'hACE1;

  // One step of the maximal-length feedback shift register.
  function automatic logic [RND_W-1:0] rnd_advance(logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Choose among the n-1 slots other than 'base' by rotating past it.
  function automatic int rot_pick(int base, int rnd, int n);
    if (n < 2) return 0;
    return (base + 1 + (rnd % (n - 1))) % n;
  endfunction

endpackage

// File: rtl/hnmru_rnd.sv
module hnmru_rnd
  import hnmru_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [RND_W-1:0] rnd_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= RND_SEED;
    else        rnd_q <= rnd_advance(rnd_q);
  end

endmodule

// File: rtl/hnmru_state.sv
module hnmru_state #(
  parameter  int SET_W  = 6,
  parameter  int GROUPS = 2,
  parameter  int WPG    = 8,
  localparam int SETS   = 1 << SET_W,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int WPG_W  = $clog2(WPG),
  localparam int WAY_W  = GRP_W + WPG_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SET_W-1:0]             rd_set,
  output logic [GRP_W-1:0]             rd_grp,
  output logic [GROUPS-1:0][WPG_W-1:0] rd_way,
  input  logic                         wr_en,
  input  logic [SET_W-1:0]             wr_set,
  input  logic [WAY_W-1:0]             wr_way
);

  logic [GRP_W-1:0] grp_q [SETS];
  logic [GRP_W-1:0] wr_grp;
  logic [WPG_W-1:0] wr_pos;

  assign wr_grp = wr_way[WAY_W-1 -: GRP_W];
  assign wr_pos = wr_way[WPG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) grp_q[s] <= '0;
    end else if (wr_en) begin
      grp_q[wr_set] <= wr_grp;
    end
  end

  assign rd_grp = grp_q[rd_set];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [WPG_W-1:0] pos_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) pos_q[s] <= '0;
      end else if (wr_en && (wr_grp == GRP_W'(g))) begin
        pos_q[wr_set] <= wr_pos;
      end
    end

    assign rd_way[g] = pos_q[rd_set];
  end

endmodule

// File: rtl/hnmru_pick.sv
module hnmru_pick
  import hnmru_pkg::*;
#(
  parameter  int GROUPS = 2,
  parameter  int WPG    = 8,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int WPG_W  = $clog2(WPG),
  localparam int WAY_W  = GRP_W + WPG_W,
  localparam int WAYS   = GROUPS * WPG
) (
  input  logic [WAYS-1:0]              set_valid,
  input  logic [GRP_W-1:0]             mru_grp,
  input  logic [GROUPS-1:0][WPG_W-1:0] mru_way,
  input  logic [RND_W-1:0]             rnd,
  output logic [WAY_W-1:0]             victim,
  output logic                         all_valid
);

  logic [WAY_W-1:0] inv_way;
  logic [GRP_W-1:0] pol_grp;
  logic [WPG_W-1:0] pol_pos;

  assign all_valid = &set_valid;

  // Lowest-numbered invalid way wins.
  always_comb begin
    inv_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!set_valid[i]) inv_way = WAY_W'(i);
    end
  end

  // Policy pick: a group other than the most recent one, then a
  // position other than that group's most recent one.
  always_comb begin
    pol_grp = GRP_W'(rot_pick(int'(mru_grp), int'(rnd[RND_W-1 -: GRP_W]), GROUPS));
    pol_pos = WPG_W'(rot_pick(int'(mru_way[pol_grp]), int'(rnd[WPG_W-1:0]), WPG));
  end

  assign victim = all_valid ? {pol_grp, pol_pos} : inv_way;

endmodule

// File: rtl/hnmru_repl.sv
module hnmru_repl
  import hnmru_pkg::*;
#(
  parameter  int SET_W          = 6,
  parameter  int GROUPS         = 2,
  parameter  int WAYS_PER_GROUP = 8,
  localparam int GRP_W          = $clog2(GROUPS),
  localparam int WPG_W          = $clog2(WAYS_PER_GROUP),
  localparam int WAY_W          = GRP_W + WPG_W,
  localparam int WAYS           = GROUPS * WAYS_PER_GROUP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_hit_way,
  input  logic [WAYS-1:0]  set_valid,
  output logic [WAY_W-1:0] victim_way
);

  logic [RND_W-1:0]             lfsr_q;
  logic [GRP_W-1:0]             rd_mru_grp;
  logic [GROUPS-1:0][WPG_W-1:0] rd_mru_way;
  logic                         all_valid;
  logic                         upd_en;
  logic [WAY_W-1:0]             upd_way;

  hnmru_rnd u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd_q (lfsr_q)
  );

  hnmru_state #(
    .SET_W  (SET_W),
    .GROUPS (GROUPS),
    .WPG    (WAYS_PER_GROUP)
  ) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_set (acc_set),
    .rd_grp (rd_mru_grp),
    .rd_way (rd_mru_way),
    .wr_en  (upd_en),
    .wr_set (acc_set),
    .wr_way (upd_way)
  );

  hnmru_pick #(
    .GROUPS (GROUPS),
    .WPG    (WAYS_PER_GROUP)
  ) u_pick (
    .set_valid (set_valid),
    .mru_grp   (rd_mru_grp),
    .mru_way   (rd_mru_way),
    .rnd       (lfsr_q),
    .victim    (victim_way),
    .all_valid (all_valid)
  );

  assign upd_en  = acc_valid;
  assign upd_way = acc_hit ? acc_hit_way : victim_way;

endmodule

// File: rtl/hnmru_chk.sv
module hnmru_chk #(
  parameter  int SET_W  = 6,
  parameter  int GROUPS = 2,
  parameter  int WPG    = 8,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int WPG_W  = $clog2(WPG),
  localparam int WAY_W  = GRP_W + WPG_W,
  localparam int WAYS   = GROUPS * WPG
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         acc_valid,
  input logic                         acc_hit,
  input logic [SET_W-1:0]             acc_set,
  input logic [WAY_W-1:0]             acc_hit_way,
  input logic [WAYS-1:0]              set_valid,
  input logic [WAY_W-1:0]             victim_way,
  input logic                         all_valid,
  input logic [GRP_W-1:0]             rd_mru_grp,
  input logic [GROUPS-1:0][WPG_W-1:0] rd_mru_way,
  input logic [15:0]                  lfsr_q
);

  logic [GRP_W-1:0] v_grp;
  logic [WPG_W-1:0] v_pos;
  logic [WPG_W-1:0] v_grp_mru;
  logic [GRP_W-1:0] hit_grp;

  assign v_grp     = victim_way[WAY_W-1 -: GRP_W];
  assign v_pos     = victim_way[WPG_W-1:0];
  assign v_grp_mru = rd_mru_way[v_grp];
  assign hit_grp   = acc_hit_way[WAY_W-1 -: GRP_W];

  // R2
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_valid |-> !set_valid[victim_way]);

  // R3
  victim_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_valid |-> (v_grp != rd_mru_grp));

  // R4
  victim_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_valid |-> (v_pos != v_grp_mru));

  // R6
  rnd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);

  // R6
  rnd_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lfsr_q[15:1] == $past(lfsr_q[14:0])));

  // R7
  hit_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=>
      (!(acc_set == $past(acc_set) && all_valid) || (v_grp != $past(hit_grp))));

  // R8
  fill_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=>
      (!(acc_set == $past(acc_set) && all_valid) || (v_grp != $past(v_grp))));

endmodule

bind hnmru_repl hnmru_chk #(
  .SET_W  (SET_W),
  .GROUPS (GROUPS),
  .WPG    (WAYS_PER_GROUP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_hit     (acc_hit),
  .acc_set     (acc_set),
  .acc_hit_way (acc_hit_way),
  .set_valid   (set_valid),
  .victim_way  (victim_way),
  .all_valid   (all_valid),
  .rd_mru_grp  (rd_mru_grp),
  .rd_mru_way  (rd_mru_way),
  .lfsr_q      (lfsr_q)
);

// File: tb/tb_hnmru_repl.sv
module tb_hnmru_repl;

  localparam int SETS = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [5:0]  acc_set;
  logic        acc_hit;
  logic [3:0]  acc_hit_way;
  logic [15:0] set_valid;
  logic [3:0]  victim_way;

  always #4 clk = ~clk;

  hnmru_repl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_set     (acc_set),
    .acc_hit     (acc_hit),
    .acc_hit_way (acc_hit_way),
    .set_valid   (set_valid),
    .victim_way  (victim_way)
  );

  int checks = 0;
  int fails  = 0;
  int m_grp [SETS];
  int m_pos [SETS][2];
  int m_rnd;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_victim(int s, logic [15:0] v);
    int g;
    int p;
    for (int i = 0; i < 16; i++) if (!v[i]) return i;
    g = 1 - m_grp[s];
    p = (m_pos[s][g] + 1 + ((m_rnd & 7) % 7)) % 8;
    return g * 8 + p;
  endfunction

  task automatic model_tick(bit av, bit hit, int hw, int s, int ev);
    int w;
    int fb;
    if (av) begin
      w = hit ? hw : ev;
      m_grp[s] = w / 8;
      m_pos[s][w / 8] = w % 8;
    end
    fb = ((m_rnd >> 15) ^ (m_rnd >> 13) ^ (m_rnd >> 12) ^ (m_rnd >> 10)) & 1;
    m_rnd = ((m_rnd << 1) | fb) & 16'hFFFF;
  endtask

  // One cycle: drive, compare the victim against the model, then advance the model.
  task automatic cyc(bit av, bit hit, int hw, int s, logic [15:0] v, output int got);
    int ev;
    string tag;
    @(negedge clk);
    acc_valid   = av;
    acc_hit     = hit;
    acc_hit_way = 4'(hw);
    acc_set     = 6'(s);
    set_valid   = v;
    #1;
    ev  = model_victim(s, v);
    got = int'(victim_way);
    tag = (v != 16'hFFFF) ? "R2" : "R5";
    check(tag, got, ev);
    if (v == 16'hFFFF) begin
      check("R3", ((got / 8) != m_grp[s]) ? 1 : 0, 1);
      check("R4", ((got % 8) != m_pos[s][got / 8]) ? 1 : 0, 1);
    end
    @(posedge clk);
    model_tick(av, hit, hw, s, ev);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int got;
    int got2;
    int v1;
    logic [15:0] rv;
    for (int s = 0; s < SETS; s++) begin
      m_grp[s] = 0;
      m_pos[s][0] = 0;
      m_pos[s][1] = 0;
    end
    m_rnd = 16'hACE1;
    rst_n = 1'b0;
    acc_valid = 1'b0;
    acc_hit = 1'b0;
    acc_hit_way = '0;
    acc_set = '0;
    set_valid = 16'hFFFF;
    repeat (3) @(posedge clk);

    // R1: first victim after reset, all valid, random source at seed
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", int'(victim_way), 10);
    acc_set = 6'd63;
    #1;
    check("R1", int'(victim_way), 10);
    @(posedge clk);
    model_tick(0, 0, 0, 0, 0);

    // R2: lowest invalid way wins
    cyc(0, 0, 0, 3, 16'hEFDF, got);
    check("R2", got, 5);
    cyc(0, 0, 0, 3, 16'h7FFF, got);
    check("R2", got, 15);

    // R7: hit in group 1 then in group 0 on set 7
    cyc(1, 1, 12, 7, 16'hFFFF, got);
    cyc(0, 0, 0, 7, 16'hFFFF, got);
    check("R7", got / 8, 0);
    cyc(1, 1, 2, 7, 16'hFFFF, got);
    cyc(0, 0, 0, 7, 16'hFFFF, got);
    check("R7", got / 8, 1);
    check("R4", ((got % 8) != 4) ? 1 : 0, 1);

    // R8: a miss fill makes the victim most recent
    cyc(1, 0, 0, 9, 16'hFFFF, v1);
    cyc(0, 0, 0, 9, 16'hFFFF, got);
    check("R8", ((got / 8) != (v1 / 8)) ? 1 : 0, 1);

    // R9: traffic on other sets and idle cycles leave set 7 alone
    cyc(1, 1, 0, 10, 16'hFFFF, got);
    cyc(1, 0, 0, 6, 16'hFFFF, got);
    cyc(0, 1, 9, 7, 16'hFFFF, got);
    cyc(0, 0, 0, 7, 16'hFFFF, got);
    check("R9", got / 8, 1);

    // R10: victim tracks set index changes cycle by cycle
    for (int k = 0; k < 20; k++) begin
      cyc(0, 0, 0, (k * 5) % SETS, 16'hFFFF, got);
      cyc(0, 0, 0, 7, 16'hFFFF, got2);
      check("R10", got2 / 8, 1);
    end

    // R5 R6 R7 R8: random traffic on a few crowded sets
    for (int k = 0; k < 4000; k++) begin
      int s;
      s  = ($urandom % 8 == 0) ? int'($urandom % SETS) : int'($urandom % 4);
      rv = ($urandom % 10 < 7) ? 16'hFFFF : (16'hFFFF & ~(16'h1 << ($urandom % 16)));
      cyc(($urandom % 5) != 0, ($urandom % 2) == 1, int'($urandom % 16), s, rv, got);
    end

    summary();
    $finish;
  end

endmodule